// File: doc/BRIEF.md
# DDR2 Burst Address Sequencer

This block turns one column address into the ordered list of column addresses that a DDR2-style burst visits, one per clock, with a valid flag and a last-beat flag. A small mode word sets the burst length (4 or 8 beats) and the ordering (sequential or interleaved). The mode word is written through a mode-set request.

A column command is taken while the sequencer is idle, or on the final beat of the running burst. In the second case the new burst follows with no idle cycle. A command that arrives in the middle of a burst is refused and flagged, and the running burst finishes unchanged. No request can stop a burst early. A mode write is taken only while idle. A write that arrives during a burst, or that carries an unsupported length code, is dropped and flagged.

In sequential eight-beat bursts the two low bits count modulo 4 inside the starting group of four. The burst then visits the other group of four with the same low-bit pattern. In interleaved bursts each beat is the start address XOR the beat number.

Top module: `ddr2_burst_seq`

## Requirements
- R1: After a synchronous active-low reset: `beat_valid`, `beat_last`, `cmd_err` and `mode_err` are 0, and the mode is four beats, sequential (`mode_bl8`=0, `mode_ilv`=0).
- R2: A mode write taken while idle is in force from the next cycle. `mrs_word[2:0]`=3'b010 selects four beats and 3'b011 selects eight. `mrs_word[3]`=0 selects sequential and 1 selects interleaved.
- R3: A mode write whose `mrs_word[2:0]` is neither 3'b010 nor 3'b011 changes nothing in the mode, and `mode_err` is high for one cycle after it.
- R4: A mode write made while `beat_valid` is high, including on the last beat, changes nothing in the mode, and `mode_err` is high for one cycle after it.
- R5: A command taken in cycle t gives `beat_valid` in cycles t+1 through t+BL. `beat_last` is high only in the final one of these cycles. No request ends a burst early.
- R6: Four-beat sequential: the two low bits are (start + n) mod 4 for beat n. Start 1 gives 1,2,3,0.
- R7: Four-beat interleaved: the two low bits are start XOR n. Start 1 gives 1,0,3,2.
- R8: Eight-beat sequential: the two low bits are (start + n) mod 4. Bit 2 equals start bit 2 for beats 0 to 3 and its inverse for beats 4 to 7. Start 5 gives 5,6,7,4,1,2,3,0.
- R9: Eight-beat interleaved: the three low bits are start XOR n. Start 5 gives 5,4,7,6,1,0,3,2.
- R10: Column bits above bit 1 (four-beat bursts) or above bit 2 (eight-beat bursts) equal the start address on every beat.
- R11: A command presented on the last beat is taken. Its first beat follows in the next cycle with no gap, and `cmd_err` stays low.
- R12: A command presented while `beat_valid` is high and `beat_last` is low is refused. `cmd_err` is high for one cycle after it, and the running burst goes on unchanged.
- R13: When a mode write and a command arrive together while idle, the mode write is applied and the command is refused with `cmd_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mrs_req | input | 1 | Mode write request |
| mrs_word | input | 4 | Mode word: [3] ordering, [2:0] length code |
| cmd_req | input | 1 | Column command request |
| cmd_col | input | COL_W | Starting column address |
| beat_valid | output | 1 | A burst beat is on `beat_col` |
| beat_col | output | COL_W | Column address of the current beat |
| beat_last | output | 1 | Current beat is the final one |
| mode_bl8 | output | 1 | 1 when eight-beat length is in force |
| mode_ilv | output | 1 | 1 when interleaved ordering is in force |
| cmd_err | output | 1 | One-cycle pulse: a command was refused |
| mode_err | output | 1 | One-cycle pulse: a mode write was dropped |

## Verification
A command can arrive in the same cycle as the final beat of a burst. It can also arrive in the same cycle as a mode write. The bench drives a command exactly on the last beat, in both lengths, and expects an unbroken stream of beats. It also drives a mode write on that last beat and expects the write to be dropped while the command is taken. With the sequencer idle, it raises a mode write and a command together and expects the new mode to take effect and the command to be refused. A behavioural model in the bench judges every one of these cycles: it holds a queue of expected beats and the expected error pulses.

// File: rtl/ddr2_burst_seq.sv
module ddr2_burst_seq #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrs_req,
  input  logic [3:0]       mrs_word,
  input  logic             cmd_req,
  input  logic [COL_W-1:0] cmd_col,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last,
  output logic             mode_bl8,
  output logic             mode_ilv,
  output logic             cmd_err,
  output logic             mode_err
);
  localparam logic [2:0] LEN_FOUR  = 3'b010;
  localparam logic [2:0] LEN_EIGHT = 3'b011;

  logic             active;
  logic [2:0]       idx;
  logic [COL_W-1:0] base;

  wire on_last  = active && (idx == {mode_bl8, 2'b11});
  wire mid      = active && !on_last;
  wire len_ok   = (mrs_word[2:0] == LEN_FOUR) || (mrs_word[2:0] == LEN_EIGHT);
  wire mrs_take = mrs_req && !active && len_ok;
  wire cmd_take = cmd_req && !mid && !(mrs_req && !active);

  wire [1:0] lo = mode_ilv ? (base[1:0] ^ idx[1:0]) : (base[1:0] + idx[1:0]);
  wire       b2 = base[2] ^ (mode_bl8 & idx[2]);

  assign beat_valid = active;
  assign beat_last  = on_last;
  assign beat_col   = {base[COL_W-1:3], b2, lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      idx      <= '0;
      base     <= '0;
      mode_bl8 <= 1'b0;
      mode_ilv <= 1'b0;
      cmd_err  <= 1'b0;
      mode_err <= 1'b0;
    end else begin
      cmd_err  <= cmd_req && !cmd_take;
      mode_err <= mrs_req && !mrs_take;
      if (mrs_take) begin
        mode_bl8 <= mrs_word[0];
        mode_ilv <= mrs_word[3];
      end
      if (cmd_take) begin
        active <= 1'b1;
        idx    <= '0;
        base   <= cmd_col;
      end else if (on_last) begin
        active <= 1'b0;
      end else if (active) begin
        idx <= idx + 3'd1;
      end
    end
  end
endmodule

// File: rtl/ddr2_burst_seq_chk.sv
module ddr2_burst_seq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mrs_req,
  input logic             cmd_req,
  input logic             beat_valid,
  input logic [COL_W-1:0] beat_col,
  input logic             beat_last,
  input logic             mode_bl8,
  input logic             mode_ilv,
  input logic             cmd_err,
  input logic             mode_err
);
  p_last_in_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);

  p_no_early_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_last |=> beat_valid);

  p_upper_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_last |=> beat_col[COL_W-1:3] == $past(beat_col[COL_W-1:3]));

  p_mode_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |=> $stable(mode_bl8) && $stable(mode_ilv));

  p_seamless_r11: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_last && cmd_req |=> beat_valid && !cmd_err);

  p_mid_reject_r12: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_last && cmd_req |=> cmd_err);

  p_cmd_err_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cmd_req));

  p_mode_err_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> $past(mrs_req));
endmodule

bind ddr2_burst_seq ddr2_burst_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mrs_req(mrs_req), .cmd_req(cmd_req),
  .beat_valid(beat_valid), .beat_col(beat_col), .beat_last(beat_last),
  .mode_bl8(mode_bl8), .mode_ilv(mode_ilv), .cmd_err(cmd_err), .mode_err(mode_err)
);

// File: tb/ddr2_burst_seq_test.sv
module ddr2_burst_seq_test;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mrs_req = 1'b0;
  logic [3:0]       mrs_word = '0;
  logic             cmd_req = 1'b0;
  logic [COL_W-1:0] cmd_col = '0;
  logic             beat_valid, beat_last, mode_bl8, mode_ilv, cmd_err, mode_err;
  logic [COL_W-1:0] beat_col;

  always #4 clk = ~clk;

  ddr2_burst_seq #(.COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .mrs_req(mrs_req), .mrs_word(mrs_word),
    .cmd_req(cmd_req), .cmd_col(cmd_col), .beat_valid(beat_valid),
    .beat_col(beat_col), .beat_last(beat_last), .mode_bl8(mode_bl8),
    .mode_ilv(mode_ilv), .cmd_err(cmd_err), .mode_err(mode_err)
  );

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    seen_edge = 0;
  string phase = "R1 reset";

  int q[$];
  bit m_bl8 = 0, m_ilv = 0, m_cerr = 0, m_merr = 0;

  function automatic int ref_beat(int start, int n, bit b8, bit il);
    int lo3 = start & 7;
    int r;
    if (!b8) r = (il ? ((lo3 ^ n) & 3) : ((lo3 + n) % 4)) | (lo3 & 4);
    else if (il) r = lo3 ^ n;
    else r = ((lo3 + n) % 4) | ((lo3 & 4) ^ (n >= 4 ? 4 : 0));
    return (start & ~7) | r;
  endfunction

  always @(posedge clk) begin
    seen_edge <= 1'b1;
    cycles <= cycles + 1;
    if (!rst_n) begin
      q.delete();
      m_bl8 = 0; m_ilv = 0; m_cerr = 0; m_merr = 0;
    end else begin
      bit in_burst, on_last, len_ok;
      in_burst = q.size() > 0;
      on_last  = q.size() == 1;
      len_ok   = (mrs_word[2:0] == 3'b010) || (mrs_word[2:0] == 3'b011);
      m_cerr = 0; m_merr = 0;
      if (in_burst) void'(q.pop_front());
      if (cmd_req) begin
        if ((in_burst && !on_last) || (!in_burst && mrs_req)) m_cerr = 1;
        else for (int n = 0; n < (m_bl8 ? 8 : 4); n++) q.push_back(ref_beat(int'(cmd_col), n, m_bl8, m_ilv));
      end
      if (mrs_req) begin
        if (in_burst || !len_ok) m_merr = 1;
        else begin m_bl8 = mrs_word[0]; m_ilv = mrs_word[3]; end
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) if (seen_edge) begin
    chk("beat_valid", int'(beat_valid), int'(q.size() > 0));
    if (q.size() > 0) begin
      chk("beat_col", int'(beat_col), q[0]);
      chk("beat_last", int'(beat_last), int'(q.size() == 1));
    end
    chk("cmd_err", int'(cmd_err), int'(m_cerr));
    chk("mode_err", int'(mode_err), int'(m_merr));
    chk("mode_bl8", int'(mode_bl8), int'(m_bl8));
    chk("mode_ilv", int'(mode_ilv), int'(m_ilv));
  end

  always @(posedge clk) if (cycles > 20000) begin
    errors++;
    $display("FAIL watchdog: actual=%0d cycles expected=%0d", cycles, 20000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic mrs(logic [3:0] w); mrs_req = 1; mrs_word = w; tick(); mrs_req = 0; endtask
  task automatic cmd(int c); cmd_req = 1; cmd_col = c[COL_W-1:0]; tick(); cmd_req = 0; endtask

  task automatic sweep(logic [3:0] w, string tag, int bl);
    phase = "R2 mode write"; mrs(w); tick();
    phase = tag;
    for (int s = 0; s < 8; s++) begin
      cmd(s + 8 * ((s * 29 + 7) % 128));
      repeat (bl + 1) tick();
    end
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    repeat (2) tick();
    sweep(4'b0010, "R6 R10 four-beat sequential", 4);
    sweep(4'b1010, "R7 R10 four-beat interleaved", 4);
    sweep(4'b0011, "R8 R10 eight-beat sequential", 8);
    sweep(4'b1011, "R9 R10 eight-beat interleaved", 8);

    phase = "R11 seamless eight";
    cmd(10'h2d5); repeat (7) tick(); cmd(10'h133); repeat (7) tick(); cmd(10'h06e);
    repeat (10) tick();
    phase = "R4 mode write on last beat";
    cmd(10'h0f1); repeat (7) tick(); mrs_req = 1; mrs_word = 4'b0010; cmd(10'h3a2); mrs_req = 0;
    repeat (10) tick();
    phase = "R12 eight-beat interruption"; cmd(10'h155); tick(); tick(); cmd(10'h2aa); repeat (10) tick();

    phase = "R2 mode write"; mrs(4'b0010); tick();
    phase = "R11 seamless four"; cmd(10'h101); repeat (3) tick(); cmd(10'h206); repeat (6) tick();
    phase = "R12 four-beat interruption"; cmd(10'h0c5); cmd(10'h3ff); cmd(10'h011); repeat (6) tick();
    phase = "R4 mode write mid burst"; cmd(10'h047); mrs(4'b1011); repeat (6) tick();
    phase = "R3 reserved length"; mrs(4'b1111); tick(); mrs(4'b1000); tick(); mrs(4'b0100); tick();
    cmd(10'h026); repeat (6) tick();
    phase = "R13 mode write with command"; mrs_req = 1; mrs_word = 4'b1011; cmd(10'h1e3); mrs_req = 0;
    repeat (3) tick(); cmd(10'h1e3); repeat (10) tick();
    phase = "R5 burst length"; cmd(10'h3fd); repeat (10) tick();
    phase = "R1 reset"; rst_n = 0; cmd(10'h0aa); tick(); rst_n = 1; repeat (3) tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule